// File: doc/BRIEF.md
# Dual-Mode Serial ADC Readout Controller

This controller sits on the host side of a three-wire link to a 12-bit, two-channel serial ADC. The three wires are an active-low chip-select that also wakes the converter, a serial clock driven by the host, and a data line driven by the converter. Each `start_i` pulse runs one conversion. The controller sets the serial clock to the level that picks the conversion clock mode, then drops chip-select. In internal mode it makes one falling clock edge to begin the conversion and then polls the data line for the end-of-conversion flag. In external mode the readout clock also drives the conversion.

After that, sixteen clock pulses move the frame in. The frame is a three-bit all-ones header, a channel bit and twelve result bits, most significant first. The controller checks the header and returns the channel, the sample and three error flags, along with a one-cycle `done_o` strobe. Chip-select then stays high for a programmable quiet time before the controller will accept another start.

The serial clock half-period is a programmable count of system clocks. In external mode the controller refuses a half-period that would stretch the conversion past its hold budget.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and after it is released, `cs_n_o` is 1, `sclk_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: A start accepted while idle drives `sclk_o` to the mode level (1 for internal, 0 for external) with `cs_n_o` still high for H system cycles, where H is the half-period. It then holds `cs_n_o` low for H cycles with `sclk_o` unchanged.
- R3: In internal mode, `sclk_o` then falls and stays low while `sdo_i` is sampled every cycle. The first cycle that samples `sdo_i` = 1 starts the readout.
- R4: If `sdo_i` is not seen high within T poll cycles, where T is `eoc_limit_i` and at least 1, the controller raises `cs_n_o`, pulses `done_o` with `eoc_timeout_o` = 1, and clears the other two flags.
- R5: The readout is 16 clock pulses, each H cycles low then H cycles high. `sdo_i` is captured in the cycle `sclk_o` rises. At the end of the 16th high phase, `sclk_o` goes low, `cs_n_o` goes high and `done_o` pulses for one cycle.
- R6: Take the captured bits in arrival order as b15 down to b0. Then `chan_o` = b12 and `data_o` = b11..b0.
- R7: If any of b15, b14 or b13 is 0, `frame_err_o` is 1 at `done_o` and `chan_o` and `data_o` are still updated. Otherwise `frame_err_o` is 0.
- R8: An external-mode start with 32·H > 28000 system cycles never lowers `cs_n_o`. In the cycle after the start, `done_o` is 1, `rate_err_o` is 1 and `busy_o` is 0.
- R9: After `cs_n_o` rises at the end of a run, `busy_o` stays 1 for max(G,1) cycles, where G is `cs_gap_i`, including the `done_o` cycle. A `start_i` pulse while `busy_o` is 1 has no effect.
- R10: A half-period input of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion (used only when idle) |
| int_mode_i | input | 1 | 1 selects internal conversion clock, 0 external |
| half_i | input | DIV_W | Serial clock half-period in system cycles |
| eoc_limit_i | input | TO_W | Poll cycles allowed for end of conversion |
| cs_gap_i | input | GAP_W | Minimum chip-select high time in cycles |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip-select / shutdown, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | A run or quiet time is in progress |
| done_o | output | 1 | One-cycle result strobe |
| chan_o | output | 1 | Channel bit of the last frame |
| data_o | output | 12 | Sample of the last frame |
| frame_err_o | output | 1 | Header of the last frame was not all ones |
| eoc_timeout_o | output | 1 | Last run timed out waiting for end of conversion |
| rate_err_o | output | 1 | Last start was refused for an over-long external clock |

## Verification
The bench steps through every cycle of each run and compares chip-select, clock, busy and strobe against a behavioural converter model.

It covers the following edges, and what a wrong design would show at each:
- Poll boundary: end of conversion arrives in the last allowed poll cycle and, in another run, one cycle late. A controller that counts one cycle off aborts a good conversion or reads a dead one.
- Rate boundary: half-periods of 875 and 876 are tried. A wrong comparison or a truncated product lets a slow clock through, or refuses a legal one.
- Corrupted header bits: an RTL that drops the sample would show stale data.
- A zero half-period: a divider that misreads it would wrap its counter and stall.
- A start pulse during readout: a controller that accepts it would restart the frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WAKE, ST_POLL, ST_READ, ST_GAP
  } rd_state_e;

  localparam int FRAME_BITS  = 16;
  localparam int HDR_BITS    = 3;
  localparam int SAMPLE_BITS = 12;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] half_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == half_i - W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_WITHIN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < half_i)) else $error("phase counter overran"); // R5
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int FW = 16,
  parameter int HW = 3,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic          full_o,
  output logic          hdr_ok_o,
  output logic          chan_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (shift_i) begin
      sr_d  = {sr_q[FW-2:0], bit_i};
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign full_o   = (cnt_q == CW'(FW));
  assign hdr_ok_o = &sr_q[FW-1 -: HW];
  assign chan_o   = sr_q[DW];
  assign data_o   = sr_q[DW-1:0];

  AST_NO_SHIFT_PAST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> !full_o) else $error("shift beyond frame"); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FW)) else $error("bit count out of range"); // R5
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int TO_W       = 16,
  parameter int GAP_W      = 16,
  parameter int BUDGET_CYC = 28000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   int_mode_i,
  input  logic [DIV_W-1:0]       half_i,
  input  logic [TO_W-1:0]        eoc_limit_i,
  input  logic [GAP_W-1:0]       cs_gap_i,
  input  logic                   sdo_i,
  output logic                   cs_n_o,
  output logic                   sclk_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   chan_o,
  output logic [SAMPLE_BITS-1:0] data_o,
  output logic                   frame_err_o,
  output logic                   eoc_timeout_o,
  output logic                   rate_err_o
);
  localparam int CNT_W      = (TO_W > GAP_W) ? TO_W : GAP_W;
  localparam int SPAN_SHIFT = $clog2(2 * FRAME_BITS);
  localparam int PW         = DIV_W + SPAN_SHIFT + 1;

  rd_state_e state_q, state_d;
  logic cs_q, cs_d, sclk_q, sclk_d, mode_q, mode_d, done_q, done_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] lim_q, lim_d, gap_q, gap_d, wcnt_q, wcnt_d;
  logic chan_q, chan_d, ferr_q, ferr_d, terr_q, terr_d, rerr_q, rerr_d;
  logic [SAMPLE_BITS-1:0] data_q, data_d;

  logic [DIV_W-1:0] half_eff;
  logic [PW-1:0]    ext_span;
  logic             rate_bad, tick, run, sh_clr, sh_en;
  logic             sh_full, sh_hdr_ok, sh_chan;
  logic [SAMPLE_BITS-1:0] sh_data;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  assign ext_span = PW'(half_eff) << SPAN_SHIFT;
  assign rate_bad = !int_mode_i && (ext_span > PW'(BUDGET_CYC));
  assign run      = (state_q == ST_SETUP) || (state_q == ST_WAKE) || (state_q == ST_READ);
  assign sh_clr   = (state_q == ST_IDLE) && start_i;
  assign sh_en    = (state_q == ST_READ) && tick && !sclk_q;

  adc_rd_tick #(.W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(run), .half_i(half_q), .tick_o(tick)
  );

  adc_rd_shift #(.FW(FRAME_BITS), .HW(HDR_BITS), .DW(SAMPLE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(sh_clr), .shift_i(sh_en), .bit_i(sdo_i),
    .full_o(sh_full), .hdr_ok_o(sh_hdr_ok), .chan_o(sh_chan), .data_o(sh_data)
  );

  always_comb begin
    state_d = state_q; cs_d = cs_q; sclk_d = sclk_q; mode_d = mode_q;
    half_d = half_q; lim_d = lim_q; gap_d = gap_q; wcnt_d = wcnt_q;
    done_d = 1'b0; chan_d = chan_q; data_d = data_q;
    ferr_d = ferr_q; terr_d = terr_q; rerr_d = rerr_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (rate_bad) begin
          done_d = 1'b1; rerr_d = 1'b1; terr_d = 1'b0; ferr_d = 1'b0;
        end else begin
          state_d = ST_SETUP; sclk_d = int_mode_i; mode_d = int_mode_i;
          half_d  = half_eff;
          lim_d   = CNT_W'(eoc_limit_i);
          gap_d   = CNT_W'(cs_gap_i);
        end
      end
      ST_SETUP: if (tick) begin
        cs_d = 1'b0; state_d = ST_WAKE;
      end
      ST_WAKE: if (tick) begin
        if (mode_q) begin
          sclk_d = 1'b0; wcnt_d = '0; state_d = ST_POLL;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_POLL: begin
        if (sdo_i) begin
          state_d = ST_READ;
        end else if (wcnt_q == lim_q - CNT_W'(1)) begin
          cs_d = 1'b1; done_d = 1'b1; wcnt_d = '0; state_d = ST_GAP;
          terr_d = 1'b1; ferr_d = 1'b0; rerr_d = 1'b0;
        end else begin
          wcnt_d = wcnt_q + CNT_W'(1);
        end
      end
      ST_READ: if (tick) begin
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else if (sh_full) begin
          sclk_d = 1'b0; cs_d = 1'b1; done_d = 1'b1; wcnt_d = '0; state_d = ST_GAP;
          chan_d = sh_chan; data_d = sh_data;
          ferr_d = !sh_hdr_ok; terr_d = 1'b0; rerr_d = 1'b0;
        end else begin
          sclk_d = 1'b0;
        end
      end
      ST_GAP: begin
        if ((wcnt_q + CNT_W'(1)) >= gap_q) state_d = ST_IDLE;
        else                               wcnt_d  = wcnt_q + CNT_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cs_q <= 1'b1; sclk_q <= 1'b0; mode_q <= 1'b0;
      half_q <= DIV_W'(1); lim_q <= '0; gap_q <= '0; wcnt_q <= '0;
      done_q <= 1'b0; chan_q <= 1'b0; data_q <= '0;
      ferr_q <= 1'b0; terr_q <= 1'b0; rerr_q <= 1'b0;
    end else begin
      state_q <= state_d; cs_q <= cs_d; sclk_q <= sclk_d; mode_q <= mode_d;
      half_q <= half_d; lim_q <= lim_d; gap_q <= gap_d; wcnt_q <= wcnt_d;
      done_q <= done_d; chan_q <= chan_d; data_q <= data_d;
      ferr_q <= ferr_d; terr_q <= terr_d; rerr_q <= rerr_d;
    end
  end

  assign cs_n_o        = cs_q;
  assign sclk_o        = sclk_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign chan_o        = chan_q;
  assign data_o        = data_q;
  assign frame_err_o   = ferr_q;
  assign eoc_timeout_o = terr_q;
  assign rate_err_o    = rerr_q;

  AST_MODE_LEVEL_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($stable(sclk_o) && (sclk_o == mode_q))) else $error("mode level moved"); // R2
  AST_POLL_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL) |-> (!sclk_o && !cs_n_o)) else $error("clock active in poll"); // R3
  AST_DONE_WITH_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_o) else $error("result while selected"); // R5
  AST_RATE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && rate_err_o) |-> (cs_n_o && !busy_o)) else $error("refused run selected"); // R8
  AST_GAP_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> (cs_n_o && !sclk_o)) else $error("gap not deselected"); // R9
endmodule

// File: tb/adc_rd_ctrl_bench.sv
`timescale 1ns/1ps
module adc_rd_ctrl_bench;
  localparam int BUDGET = 28000;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, int_mode_i, sdo_i;
  logic [15:0] half_i, eoc_limit_i, cs_gap_i;
  logic cs_n_o, sclk_o, busy_o, done_o, chan_o, frame_err_o, eoc_timeout_o, rate_err_o;
  logic [11:0] data_o;

  int checks = 0;
  int failures = 0;

  logic [15:0] frame_r = 16'h0;
  int eoc_dly = 0;
  int ph = 0, idx = 0, cnt = 0;
  logic pcs = 1'b1, psclk = 1'b0;

  always #2.5 clk = ~clk;

  adc_rd_ctrl u_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .int_mode_i(int_mode_i),
    .half_i(half_i), .eoc_limit_i(eoc_limit_i), .cs_gap_i(cs_gap_i), .sdo_i(sdo_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o), .done_o(done_o),
    .chan_o(chan_o), .data_o(data_o), .frame_err_o(frame_err_o),
    .eoc_timeout_o(eoc_timeout_o), .rate_err_o(rate_err_o)
  );

  // Behavioural converter: data changes after falling clock edges.
  always @(negedge clk) begin
    if (cs_n_o !== 1'b0) begin
      sdo_i = 1'b0; ph = 0;
    end else if (pcs) begin
      if (!sclk_o) begin ph = 2; idx = 0; sdo_i = frame_r[15]; end
      else begin ph = 1; sdo_i = 1'b0; end
    end else if (ph == 1 && psclk && !sclk_o) begin
      if (eoc_dly == 0) begin ph = 2; idx = 0; sdo_i = frame_r[15]; end
      else begin ph = 3; cnt = eoc_dly; end
    end else if (ph == 3) begin
      cnt--;
      if (cnt == 0) begin ph = 2; idx = 0; sdo_i = frame_r[15]; end
    end else if (ph == 2 && psclk && !sclk_o) begin
      idx++;
      sdo_i = (idx < 16) ? frame_r[15-idx] : 1'b0;
    end
    pcs = cs_n_o; psclk = sclk_o;
  end

  task automatic cmp(input logic ecs, input logic esclk, input logic ebusy,
                     input logic edone, input string req);
    checks++;
    if (cs_n_o !== ecs || sclk_o !== esclk || busy_o !== ebusy || done_o !== edone) begin
      failures++;
      $display("FAIL %s cs/sclk/busy/done actual=%b%b%b%b expected=%b%b%b%b",
               req, cs_n_o, sclk_o, busy_o, done_o, ecs, esclk, ebusy, edone);
    end
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic run(input bit intm, input int h, input int d, input int t,
                     input int g, input logic [15:0] fr, input bit glitch);
    int hh;
    int ng;
    hh = (h == 0) ? 1 : h;   // R10
    ng = (g < 1) ? 1 : g;
    frame_r = fr; eoc_dly = d;
    int_mode_i = intm; half_i = 16'(h); eoc_limit_i = 16'(t); cs_gap_i = 16'(g);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!intm && 32 * hh > BUDGET) begin
      chk("R8 rate flag", {15'b0, rate_err_o}, 16'd1);
      chk("R8 other flags", {14'b0, eoc_timeout_o, frame_err_o}, 16'd0);
      cmp(1'b1, 1'b0, 1'b0, 1'b1, "R8");
      cmp(1'b1, 1'b0, 1'b0, 1'b0, "R8");
      return;
    end
    for (int i = 0; i < hh; i++) cmp(1'b1, intm, 1'b1, 1'b0, "R2 setup");
    for (int i = 0; i < hh; i++) cmp(1'b0, intm, 1'b1, 1'b0, "R2 wake");
    if (intm) begin
      if (d <= t - 1) begin
        for (int i = 0; i < d + 1; i++) cmp(1'b0, 1'b0, 1'b1, 1'b0, "R3 poll");
      end else begin
        for (int i = 0; i < t; i++) cmp(1'b0, 1'b0, 1'b1, 1'b0, "R4 poll");
        chk("R4 timeout flag", {15'b0, eoc_timeout_o}, 16'd1);
        chk("R4 other flags", {14'b0, rate_err_o, frame_err_o}, 16'd0);
        cmp(1'b1, 1'b0, 1'b1, 1'b1, "R4 abort");
        for (int i = 0; i < ng - 1; i++) cmp(1'b1, 1'b0, 1'b1, 1'b0, "R9 gap");
        cmp(1'b1, 1'b0, 1'b0, 1'b0, "R9 idle");
        return;
      end
    end
    for (int b = 0; b < 16; b++) begin
      for (int i = 0; i < hh; i++) begin
        if (glitch && b == 5 && i == 0) start_i = 1'b1;  // R9 ignored start
        cmp(1'b0, 1'b0, 1'b1, 1'b0, "R5 low");
        start_i = 1'b0;
      end
      for (int i = 0; i < hh; i++) cmp(1'b0, 1'b1, 1'b1, 1'b0, "R5 high");
    end
    chk("R6 channel", {15'b0, chan_o}, {15'b0, fr[12]});
    chk("R6 data", {4'b0, data_o}, {4'b0, fr[11:0]});
    chk("R7 frame flag", {15'b0, frame_err_o}, {15'b0, ~&fr[15:13]});
    chk("R5 other flags", {14'b0, rate_err_o, eoc_timeout_o}, 16'd0);
    cmp(1'b1, 1'b0, 1'b1, 1'b1, "R5 done");
    for (int i = 0; i < ng - 1; i++) cmp(1'b1, 1'b0, 1'b1, 1'b0, "R9 gap");
    cmp(1'b1, 1'b0, 1'b0, 1'b0, "R9 idle");
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; int_mode_i = 1'b0;
    half_i = 16'd1; eoc_limit_i = 16'd1; cs_gap_i = 16'd0;
    fork
      begin
        repeat (3) @(negedge clk);
        cmp(1'b1, 1'b0, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        cmp(1'b1, 1'b0, 1'b0, 1'b0, "R1 after reset");
        run(1'b1, 2, 3, 20, 4, 16'hEAC3, 1'b0);
        run(1'b0, 1, 0, 1, 0, 16'hF5A5, 1'b1);
        run(1'b0, 0, 0, 1, 2, 16'hE001, 1'b0);   // R10 zero half-period
        run(1'b1, 3, 0, 1, 1, 16'hFFFF, 1'b0);   // R3 last allowed poll
        run(1'b1, 1, 5, 5, 3, 16'hE123, 1'b0);   // R4 one cycle late
        run(1'b1, 1, 4, 5, 0, 16'hF456, 1'b0);   // R3 boundary accepted
        run(1'b0, 2, 0, 1, 1, 16'h9123, 1'b0);   // R7
        run(1'b1, 1, 2, 9, 1, 16'hA7FF, 1'b0);   // R7
        run(1'b0, 876, 0, 1, 1, 16'hE000, 1'b0); // R8 refused
        run(1'b0, 875, 0, 1, 1, 16'hE800, 1'b0); // R8 limit accepted
      end
      begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule